// File: doc/BRIEF.md
# Dual Page Map Memory

This block holds two page maps side by side: a monitor map and a user map, each with 512 entries of 18 bits, 1024 entries in total. One select input picks which of the two maps an access goes to. A 9-bit index picks the entry inside that map. Read data follows the index and the select flag in the same cycle, with no clock edge in between. A single write lands on the next clock edge.

Besides single writes, the block has a block-fill operation. It copies one value into four consecutive entries of a map, one entry per cycle, and steps an index register as it goes. A fill needs the upper half of its data word to be zero. It takes the map select and the data at the moment it is accepted and keeps them for the whole fill. While a fill runs, the block reports busy and turns away every other write. The block does not translate addresses; it only stores map entries.

Top module: `dual_page_map`

## Requirements
- R1: With `busy` low and `blk_wr_en` low, `wr_en` high stores `wr_data` (18 bits) at entry `idx_in` of the map chosen by `map_user` (1 = user map, 0 = monitor map) on the next rising edge.
- R2: `rd_data` shows, in the same cycle, the entry at `idx_in` of the map selected by the current value of `map_user`.
- R3: The two maps are independent: a write to one map leaves the entry at the same index of the other map unchanged.
- R4: A fill request (`blk_wr_en` high while `busy` is low and `wr_data[17:9]` is zero) stores `wr_data` at indices i, i+1, i+2 and i+3, where i is the `idx_in` of the request. The entry at i+k is written on the rising edge k+1 cycles after acceptance, so it is readable from the cycle after that edge.
- R5: The fill index wraps modulo 512 and never leaves the map it started in. For example, starting at 510 writes 510, 511, 0 and 1.
- R6: `idx_out` resets to 0. It loads the start index when a fill is accepted and rises by one, modulo 512, for each entry stored, so it ends at the start index + 4. At all other times it holds its value.
- R7: `busy` resets low, is high for exactly the four cycles after a fill is accepted, and then falls.
- R8: While `busy` is high, both `wr_en` and `blk_wr_en` are ignored.
- R9: A fill request with any bit of `wr_data[17:9]` set is refused: `busy` stays low, `idx_out` holds, and no entry changes.
- R10: A fill writes to the map that `map_user` selected in its request cycle, even if `map_user` changes while the fill runs.
- R11: In a cycle with `blk_wr_en` high, no single write happens, even if the fill request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| map_user | input | 1 | Map select: 1 = user map, 0 = monitor map |
| idx_in | input | 9 | Entry index for read, single write, or fill start |
| wr_en | input | 1 | Single-entry write request |
| blk_wr_en | input | 1 | Four-entry fill request |
| wr_data | input | 18 | Write data; upper 9 bits must be zero for a fill |
| rd_data | output | 18 | Entry at `idx_in` of the selected map, same cycle |
| idx_out | output | 9 | Running fill index; start + 4 once a fill completes |
| busy | output | 1 | High while a fill is storing entries |

## Verification
A combinational read and a running fill often happen in the same cycle, and the read can target the very entry the fill is about to store. The bench points the read at the fill's start index in the first busy cycle, where it expects the old contents. It reads the same index again in the next cycle, where it expects the fill value. In a second fill, the bench flips the map select during the busy cycles, so the reads come from the other map and must show no change there. Write attempts made during those same busy cycles are judged afterwards by reading back the entries they targeted.

// File: rtl/pmap_pkg.sv
// Package pmap_pkg
// Holds the default sizes and the map-select type shared by every
// module of the dual page map. It assumes exactly two maps.
package pmap_pkg;
    localparam int unsigned PM_ENTRY_W = 18;
    localparam int unsigned PM_IDX_W   = 9;
    localparam int unsigned PM_BURST   = 4;
    localparam int unsigned PM_MAPS    = 2;

    typedef enum logic {
        MAP_MONITOR = 1'b0,
        MAP_USER    = 1'b1
    } map_sel_e;
endpackage

// File: rtl/pmap_bank.sv
// Module pmap_bank
// Storage for one page map: 2**IDX_W entries with one write port and
// one asynchronous read port.
// Assumes the caller gates the write enable, so only one writer is
// active per cycle. The array has no reset; its contents are undefined
// until written.
module pmap_bank #(
    parameter int ENTRY_W = pmap_pkg::PM_ENTRY_W,
    parameter int IDX_W   = pmap_pkg::PM_IDX_W
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Store one entry on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read path: the addressed entry, with no register in between.
    assign rdata = mem[raddr];
endmodule

// File: rtl/pmap_burst.sv
// Module pmap_burst
// Runs the four-entry fill. It accepts a request only when idle and
// when the upper half of the data is zero. At acceptance it captures
// the data, the map and the start index. It then asserts busy for
// BURST_LEN cycles, stepping its cursor once per stored entry.
// The cursor wraps naturally at 2**IDX_W. Reset is synchronous and
// active low.
module pmap_burst #(
    parameter int ENTRY_W   = pmap_pkg::PM_ENTRY_W,
    parameter int IDX_W     = pmap_pkg::PM_IDX_W,
    parameter int BURST_LEN = pmap_pkg::PM_BURST
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ENTRY_W-1:0]  req_data,
    input  logic [IDX_W-1:0]    req_idx,
    input  pmap_pkg::map_sel_e  req_map,
    output logic                busy,
    output logic [IDX_W-1:0]    cursor,
    output pmap_pkg::map_sel_e  map_q,
    output logic [ENTRY_W-1:0]  data_q
);
    localparam int LEFT_W = ENTRY_W - ENTRY_W / 2;
    localparam int CNT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    logic             left_clear;
    logic             accept;
    logic [CNT_W-1:0] cnt;

    assign left_clear = (req_data[ENTRY_W-1 -: LEFT_W] == '0);
    assign accept     = req && !busy && left_clear;

    // Busy flag and the count of entries stored so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    // Cursor: loads the start index, then steps once per stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor <= '0;
        end else if (accept) begin
            cursor <= req_idx;
        end else if (busy) begin
            cursor <= cursor + 1'b1;
        end
    end

    // Capture the fill value and target map at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            map_q  <= pmap_pkg::MAP_MONITOR;
        end else if (accept) begin
            data_q <= req_data;
            map_q  <= req_map;
        end
    end
endmodule

// File: rtl/pmap_wr_arb.sv
// Module pmap_wr_arb
// Chooses the one writer for the map banks in each cycle. A running
// fill always wins. A single write goes through only when no fill runs
// and no fill is being requested. Produces one write enable per map.
// Assumes exactly pmap_pkg::PM_MAPS banks.
module pmap_wr_arb #(
    parameter int ENTRY_W = pmap_pkg::PM_ENTRY_W,
    parameter int IDX_W   = pmap_pkg::PM_IDX_W
) (
    input  logic                          burst_busy,
    input  logic [IDX_W-1:0]              burst_idx,
    input  pmap_pkg::map_sel_e            burst_map,
    input  logic [ENTRY_W-1:0]            burst_data,
    input  logic                          wr_en,
    input  logic                          blk_wr_en,
    input  logic [IDX_W-1:0]              idx_in,
    input  pmap_pkg::map_sel_e            sel_map,
    input  logic [ENTRY_W-1:0]            wr_data,
    output logic [pmap_pkg::PM_MAPS-1:0]  bank_we,
    output logic [IDX_W-1:0]              waddr,
    output logic [ENTRY_W-1:0]            wdata
);
    logic               single_go;
    pmap_pkg::map_sel_e target;

    assign single_go = wr_en && !burst_busy && !blk_wr_en;

    // Route the address, data and map of whichever writer owns the cycle.
    always_comb begin
        if (burst_busy) begin
            waddr  = burst_idx;
            wdata  = burst_data;
            target = burst_map;
        end else begin
            waddr  = idx_in;
            wdata  = wr_data;
            target = sel_map;
        end
    end

    // One enable per bank, decoded from the target map.
    for (genvar g = 0; g < int'(pmap_pkg::PM_MAPS); g++) begin : g_we
        assign bank_we[g] = (burst_busy || single_go) && (int'(target) == g);
    end
endmodule

// File: rtl/dual_page_map.sv
// Module dual_page_map
// Top of the dual page map: one bank per map, the fill sequencer and
// the write arbiter. Reads are combinational from idx_in and map_user.
// Assumes the caller keeps the upper half of the data zero for fills;
// a fill request that breaks this rule is dropped. Reset is
// synchronous and active low.
module dual_page_map #(
    parameter int ENTRY_W   = pmap_pkg::PM_ENTRY_W,
    parameter int IDX_W     = pmap_pkg::PM_IDX_W,
    parameter int BURST_LEN = pmap_pkg::PM_BURST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_user,
    input  logic [IDX_W-1:0]   idx_in,
    input  logic               wr_en,
    input  logic               blk_wr_en,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [IDX_W-1:0]   idx_out,
    output logic               busy
);
    localparam int MAPS = int'(pmap_pkg::PM_MAPS);

    pmap_pkg::map_sel_e       sel_map;
    pmap_pkg::map_sel_e       burst_map;
    logic [ENTRY_W-1:0]       burst_data;
    logic [IDX_W-1:0]         burst_idx;
    logic                     burst_busy;
    logic [MAPS-1:0]          bank_we;
    logic [IDX_W-1:0]         waddr;
    logic [ENTRY_W-1:0]       wdata;
    logic [ENTRY_W-1:0]       bank_rd [MAPS];

    assign sel_map = map_user ? pmap_pkg::MAP_USER : pmap_pkg::MAP_MONITOR;

    pmap_burst #(
        .ENTRY_W   (ENTRY_W),
        .IDX_W     (IDX_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (blk_wr_en),
        .req_data (wr_data),
        .req_idx  (idx_in),
        .req_map  (sel_map),
        .busy     (burst_busy),
        .cursor   (burst_idx),
        .map_q    (burst_map),
        .data_q   (burst_data)
    );

    pmap_wr_arb #(
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .burst_busy (burst_busy),
        .burst_idx  (burst_idx),
        .burst_map  (burst_map),
        .burst_data (burst_data),
        .wr_en      (wr_en),
        .blk_wr_en  (blk_wr_en),
        .idx_in     (idx_in),
        .sel_map    (sel_map),
        .wr_data    (wr_data),
        .bank_we    (bank_we),
        .waddr      (waddr),
        .wdata      (wdata)
    );

    // One storage bank per map, all sharing the read index.
    for (genvar g = 0; g < MAPS; g++) begin : g_bank
        pmap_bank #(
            .ENTRY_W (ENTRY_W),
            .IDX_W   (IDX_W)
        ) u_bank (
            .clk   (clk),
            .we    (bank_we[g]),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (idx_in),
            .rdata (bank_rd[g])
        );
    end

    // Select the read data of the current map.
    assign rd_data = bank_rd[int'(sel_map)];
    assign idx_out = burst_idx;
    assign busy    = burst_busy;
endmodule

// File: rtl/pmap_checker.sv
// Module pmap_checker
// Temporal checks on the ports of dual_page_map, attached by bind.
// Tracks the length of the current busy run with a counter, so no
// property needs a long history window.
module pmap_checker #(
    parameter int ENTRY_W   = pmap_pkg::PM_ENTRY_W,
    parameter int IDX_W     = pmap_pkg::PM_IDX_W,
    parameter int BURST_LEN = pmap_pkg::PM_BURST
) (
    input logic               clk,
    input logic               rst_n,
    input logic               map_user,
    input logic [IDX_W-1:0]   idx_in,
    input logic               wr_en,
    input logic               blk_wr_en,
    input logic [ENTRY_W-1:0] wr_data,
    input logic [ENTRY_W-1:0] rd_data,
    input logic [IDX_W-1:0]   idx_out,
    input logic               busy
);
    localparam int LEFT_W = ENTRY_W - ENTRY_W / 2;

    logic        left_zero;
    logic        fill_ok;
    int unsigned run;

    assign left_zero = (wr_data[ENTRY_W-1 -: LEFT_W] == '0);
    assign fill_ok   = !busy && blk_wr_en && left_zero;

    // Count consecutive busy cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    p_fill_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |=> busy);
    p_busy_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < BURST_LEN));
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == BURST_LEN));
    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blk_wr_en && !left_zero) |=> (!busy && $stable(idx_out)));
    p_load_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |=> (idx_out == $past(idx_in)));
    p_step_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (idx_out == IDX_W'($past(idx_out) + 1'b1)));
    p_hold_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fill_ok) |=> $stable(idx_out));
    p_single_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && !blk_wr_en) |=>
            ((idx_in != $past(idx_in)) || (map_user != $past(map_user))
             || (rd_data == $past(wr_data))));
endmodule

bind dual_page_map pmap_checker #(
    .ENTRY_W   (ENTRY_W),
    .IDX_W     (IDX_W),
    .BURST_LEN (BURST_LEN)
) u_pmap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_user  (map_user),
    .idx_in    (idx_in),
    .wr_en     (wr_en),
    .blk_wr_en (blk_wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .idx_out   (idx_out),
    .busy      (busy)
);

// File: tb/sim_dual_page_map.sv
// Scoreboard bench: driver tasks push expected items at each falling
// edge; a monitor pops and compares them a few ns later in the same
// cycle.
module sim_dual_page_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_user = 1'b0;
    logic [8:0]  idx_in = '0;
    logic        wr_en = 1'b0;
    logic        blk_wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic [8:0]  idx_out;
    logic        busy;

    always #5 clk = ~clk;

    dual_page_map u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_user  (map_user),
        .idx_in    (idx_in),
        .wr_en     (wr_en),
        .blk_wr_en (blk_wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .idx_out   (idx_out),
        .busy      (busy)
    );

    typedef struct {
        int          kind;   // 0 rd_data, 1 idx_out, 2 busy
        logic [17:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [17:0] mdl [2][512];
    int          n_checks = 0;
    int          n_errors = 0;
    int          last_idx = 0;
    bit          done = 1'b0;

    task automatic push(input int kind, input logic [17:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare everything expected for this cycle.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [17:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {9'b0, idx_out};
                    default: act = {17'b0, busy};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic single_wr(input int m, input int idx, input logic [17:0] d);
        map_user = m[0]; idx_in = 9'(idx); wr_data = d; wr_en = 1'b1; blk_wr_en = 1'b0;
        mdl[m][idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input int m, input int idx, input string tag);
        map_user = m[0]; idx_in = 9'(idx); wr_en = 1'b0; blk_wr_en = 1'b0;
        push(0, mdl[m][idx], tag);
        @(negedge clk);
    endtask

    // Fill from s in map m. flip: read the other map while busy.
    // poke: attempt a single write and a second fill while busy.
    task automatic fill(input int m, input int s, input logic [17:0] d,
                        input bit flip, input bit poke);
        int rm = flip ? 1 - m : m;
        int pt = (s + 8) % 512;
        map_user = m[0]; idx_in = 9'(s); wr_data = d; blk_wr_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        blk_wr_en = 1'b0;
        // first busy cycle: start entry not yet stored
        map_user = rm[0]; idx_in = 9'(s);
        push(2, 18'd1, "R7 busy first cycle");
        push(1, 18'(s), "R6 idx loaded");
        push(0, mdl[rm][s], "R2 read before store");
        for (int k = 0; k < 4; k++) mdl[m][(s + k) % 512] = d;
        @(negedge clk);
        push(2, 18'd1, "R7 busy second cycle");
        push(1, 18'((s + 1) % 512), "R6 idx step 1");
        push(0, mdl[rm][s], flip ? "R10 other map untouched" : "R4 start entry stored");
        @(negedge clk);
        idx_in = 9'(pt);
        push(2, 18'd1, "R7 busy third cycle");
        push(1, 18'((s + 2) % 512), "R6 idx step 2");
        push(0, mdl[rm][pt], "R2 read during fill");
        if (poke) begin
            wr_en = 1'b1; blk_wr_en = 1'b1; wr_data = 18'h00155;
        end
        @(negedge clk);
        wr_en = 1'b0; blk_wr_en = 1'b0;
        push(2, 18'd1, "R7 busy fourth cycle");
        push(1, 18'((s + 3) % 512), "R6 idx step 3");
        @(negedge clk);
        push(2, 18'd0, "R7 busy falls");
        push(1, 18'((s + 4) % 512), "R5 R6 idx end");
        last_idx = (s + 4) % 512;
        @(negedge clk);
        push(1, 18'(last_idx), "R6 idx holds");
        push(2, 18'd0, "R8 second fill ignored");
        for (int k = 0; k < 5; k++) begin
            read_chk(m, (s + k) % 512, "R4 R5 fill contents");
            read_chk(1 - m, (s + k) % 512, "R3 R10 other map unchanged");
        end
        read_chk(m, pt, "R8 write while busy ignored");
    endtask

    // Refused fill with nonzero upper half, single write also requested.
    task automatic bad_fill(input int m, input int s);
        map_user = m[0]; idx_in = 9'(s); wr_data = 18'h3FE05;
        blk_wr_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        blk_wr_en = 1'b0; wr_en = 1'b0;
        push(2, 18'd0, "R9 refused fill not busy");
        push(1, 18'(last_idx), "R9 idx holds");
        push(0, mdl[m][s], "R11 no single write with fill request");
        @(negedge clk);
        for (int k = 0; k < 4; k++) read_chk(m, (s + k) % 512, "R9 entries unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push(2, 18'd0, "R7 reset busy");
        push(1, 18'd0, "R6 reset idx");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // prefill both maps with distinct values
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) begin
                for (int i = 0; i < 16; i++) begin
                    int base = (b == 0) ? 0 : (b == 1) ? 100 : (b == 2) ? 200 : 496;
                    single_wr(m, base + i, 18'(((base + i) * 977 + m * 55555) & 18'h3FFFF));
                end
            end
        end
        read_chk(0, 5, "R1 single write monitor map");
        read_chk(1, 5, "R3 user map distinct");
        single_wr(1, 7, 18'h2BEEF);
        read_chk(1, 7, "R1 single write user map");
        read_chk(0, 7, "R3 monitor map untouched");
        push(1, 18'd0, "R6 idx holds after single writes");
        read_chk(1, 511, "R2 read top entry");
        fill(0, 100, 18'h001A5, 1'b0, 1'b1);
        fill(1, 510, 18'h000FF, 1'b1, 1'b0);
        bad_fill(0, 200);
        fill(1, 200, 18'h00001, 1'b0, 1'b1);
        fill(0, 508, 18'h001FE, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule